// File: doc/BRIEF.md
# Dual-Role SPI Controller with Status Register

This block is one SPI channel that works either as a bus master, generating the serial clock and its own select line, or as a slave, answering an external master. Software reaches it through four 16-bit registers on a simple memory-mapped bus. The four registers are:

- control, which sets enable, role, divider and interrupt enable;
- transmit data;
- receive data;
- status.

A single-byte transmit buffer and a single-byte receive buffer sit between the registers and one 8-bit shift engine per role. Transfers are 8 bits, most significant bit first, in SPI mode 0.

Software writes a byte to the transmit register. As soon as the active engine can accept it, the byte moves into the shift register. In master mode this move also starts a transfer. Each completed byte lands in the receive buffer and raises the full flag. With the receive interrupt enabled, that flag drives the interrupt output. Status bit 2 has two meanings: in master mode it reports a transfer in progress, and in slave mode it mirrors the select input.

The register bus has no back-pressure. An access is taken in the cycle in which `bus_sel` is high. Writes take effect at the following clock edge. Read data is valid combinationally during the access cycle. A read of the receive register consumes its contents at that same edge.

Top module: `spi_port_ctrl`

## Requirements
- R1: Registers are decoded at byte offsets 0x0 (status), 0x2 (transmit data), 0x4 (receive data) and 0x6 (control). The transmit register reads back the last written byte, and the control register reads back its five defined bits.
- R2: Status bits [15:3] always read 0. Bits above the defined fields of a write are expected to be 0.
- R3: In master mode, status bit 2 reads 1 from the cycle a transfer starts until it completes, and 0 otherwise. It is 0 after reset, and it has already fallen by the time the receive-full flag appears.
- R4: In slave mode, status bit 2 reads 1 while the select input `s_ss_n_i` is low and 0 while it is high, after a two-flop synchronizer delay.
- R5: Status bit 1 (receive full) is 0 after reset. It becomes 1 when a completed byte enters the receive buffer, and returns to 0 when the receive register is read.
- R6: Status bit 0 (transmit empty) is 1 after reset. It reads 0 after a transmit write until the engine takes the byte, and 1 again once the byte is in the shift register.
- R7: `irq_o` is 1 exactly when control bit 4 (receive interrupt enable) is 1 and the receive-full flag is 1. Reading the receive register drops it.
- R8: Control bit 0 enables transfers, bit 1 selects master (1) or slave (0), bits [3:2] choose the divider and bit 4 enables the receive interrupt. A write that changes bit 1 while a master transfer runs, or while the enabled slave is selected, leaves the role unchanged.
- R9: A master transfer shifts 8 bits MSB first in mode 0. SCK idles low, MISO is sampled on the rising edge and MOSI changes on the falling edge. Each SCK half period lasts 2^div clock cycles, so `m_ss_n_o` is low for exactly 16*2^div cycles.
- R10: The slave samples MOSI on synchronized rising SCK edges and shifts MISO on falling edges, MSB first. The MSB of the loaded byte is presented before the first rising edge. If no byte was loaded for a frame, that frame returns 0x00.
- R11: A byte that completes while the receive buffer is still full overwrites it, and the full flag stays 1.
- R12: With control bit 0 clear, a written transmit byte stays pending: transmit empty reads 0 and no transfer starts. Setting bit 0 then starts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid during a read access |
| irq_o | output | 1 | Receive interrupt request |
| m_sck_o | output | 1 | Master serial clock |
| m_mosi_o | output | 1 | Master serial data out |
| m_miso_i | input | 1 | Master serial data in |
| m_ss_n_o | output | 1 | Master select, low during a transfer |
| s_sck_i | input | 1 | Slave serial clock from the external master |
| s_ss_n_i | input | 1 | Slave select, active low |
| s_mosi_i | input | 1 | Slave serial data in |
| s_miso_o | output | 1 | Slave serial data out |

## Verification
The master path is swept over all 256 transmit bytes, each paired with a distinct reply computed arithmetically. Because the sent and received bytes differ, a bit-order or sampling-edge fault shows up in one direction even when the other direction looks correct. Each divider setting is run once, and the select-low and SCK-high cycle counts are measured, which separates a wrong half-period from a wrong bit count. The slave path is swept over all 256 incoming bytes against a different reply byte, and is also run with no byte loaded and with two frames back to back, which covers the zero-fill and overwrite cases. A role write issued during a master transfer and another issued while the slave is selected check that the role lock holds in both roles.

// File: rtl/spi_ctrl_pkg.sv
package spi_ctrl_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFF_STAT = 3'h0;
  localparam logic [ADDR_W-1:0] OFF_TXD  = 3'h2;
  localparam logic [ADDR_W-1:0] OFF_RXD  = 3'h4;
  localparam logic [ADDR_W-1:0] OFF_CTL  = 3'h6;
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_MST_BIT = 1;
  localparam int CTL_DIV_LO  = 2;
  localparam int ST_TXE_BIT  = 0;
  localparam int ST_RXF_BIT  = 1;
  localparam int ST_ACT_BIT  = 2;
endpackage

// File: rtl/spi_regs.sv
module spi_regs import spi_ctrl_pkg::*; #(
  parameter int REG_W  = 16,
  parameter int CHAR_W = 8,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              eng_ready,
  input  logic              role_lock,
  input  logic              act_bit,
  input  logic              rx_done,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              load,
  output logic [CHAR_W-1:0] tx_data,
  output logic              ctl_en,
  output logic              ctl_master,
  output logic [DIV_W-1:0]  ctl_div,
  output logic              irq
);
  localparam int RXIE_BIT = CTL_DIV_LO + DIV_W;

  logic ctl_rxie, tx_empty, rx_full;
  logic [CHAR_W-1:0] txbuf, rxbuf;
  logic wr_tx, wr_ctl, rd_rx;

  assign wr_tx  = bus_sel && bus_wr && (bus_addr == OFF_TXD);
  assign wr_ctl = bus_sel && bus_wr && (bus_addr == OFF_CTL);
  assign rd_rx  = bus_sel && !bus_wr && (bus_addr == OFF_RXD);
  assign load    = !tx_empty && eng_ready;
  assign tx_data = txbuf;
  assign irq     = ctl_rxie && rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbuf      <= '0;
      rxbuf      <= '0;
      tx_empty   <= 1'b1;
      rx_full    <= 1'b0;
      ctl_en     <= 1'b0;
      ctl_master <= 1'b0;
      ctl_div    <= '0;
      ctl_rxie   <= 1'b0;
    end else begin
      if (wr_tx) begin
        txbuf    <= bus_wdata[CHAR_W-1:0];
        tx_empty <= 1'b0;
      end else if (load) begin
        tx_empty <= 1'b1;
      end
      if (rx_done) begin
        rxbuf   <= rx_data;
        rx_full <= 1'b1;
      end else if (rd_rx) begin
        rx_full <= 1'b0;
      end
      if (wr_ctl) begin
        ctl_en   <= bus_wdata[CTL_EN_BIT];
        ctl_div  <= bus_wdata[CTL_DIV_LO +: DIV_W];
        ctl_rxie <= bus_wdata[RXIE_BIT];
        if (!role_lock) ctl_master <= bus_wdata[CTL_MST_BIT];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_STAT: begin
        bus_rdata[ST_ACT_BIT] = act_bit;
        bus_rdata[ST_RXF_BIT] = rx_full;
        bus_rdata[ST_TXE_BIT] = tx_empty;
      end
      OFF_TXD: bus_rdata[CHAR_W-1:0] = txbuf;
      OFF_RXD: bus_rdata[CHAR_W-1:0] = rxbuf;
      OFF_CTL: bus_rdata[RXIE_BIT:0] = {ctl_rxie, ctl_div, ctl_master, ctl_en};
      default: bus_rdata = '0;
    endcase
  end

  assert_full_from_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_done));
  assert_read_drops_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !rx_done) |=> !irq);
  assert_write_fills_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> !tx_empty);
  assert_role_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && role_lock) |=> $stable(ctl_master));
  assert_rsvd_write_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl |-> bus_wdata[REG_W-1:RXIE_BIT+1] == '0) and
    (wr_tx  |-> bus_wdata[REG_W-1:CHAR_W] == '0));
endmodule

// File: rtl/spi_mst_eng.sv
module spi_mst_eng #(
  parameter int CHAR_W = 8,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic [DIV_W-1:0]  div,
  input  logic              miso,
  output logic              busy,
  output logic              ready,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [CHAR_W-1:0] rx_data
);
  localparam int HC_W = 1 << DIV_W;
  localparam int BC_W = $clog2(CHAR_W);
  localparam logic [BC_W-1:0] LAST = BC_W'(CHAR_W - 1);

  logic [HC_W-1:0]   hcnt, lim;
  logic [BC_W-1:0]   bcnt;
  logic [CHAR_W-1:0] sh;
  logic              sbit;

  assign lim   = (HC_W'(1) << div) - HC_W'(1);
  assign ready = !busy;
  assign mosi  = sh[CHAR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      done    <= 1'b0;
      hcnt    <= '0;
      bcnt    <= '0;
      sh      <= '0;
      sbit    <= 1'b0;
      rx_data <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          sh   <= tx_data;
          hcnt <= '0;
          bcnt <= '0;
          sck  <= 1'b0;
        end
      end else if (hcnt == lim) begin
        hcnt <= '0;
        if (!sck) begin
          sck  <= 1'b1;
          sbit <= miso;
        end else begin
          sck <= 1'b0;
          if (bcnt == LAST) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_data <= {sh[CHAR_W-2:0], sbit};
          end else begin
            bcnt <= bcnt + 1'b1;
            sh   <= {sh[CHAR_W-2:0], sbit};
          end
        end
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  assert_done_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_idle_sck_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
endmodule

// File: rtl/spi_slv_eng.sv
module spi_slv_eng #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              load,
  input  logic [CHAR_W-1:0] tx_data,
  input  logic              sck_i,
  input  logic              ss_n_i,
  input  logic              mosi_i,
  output logic              miso,
  output logic              selected,
  output logic              active,
  output logic              ready,
  output logic              done,
  output logic [CHAR_W-1:0] rx_data
);
  localparam int NSYNC = 3;
  localparam logic [NSYNC-1:0] SYNC_RST = 3'b010;
  localparam int BC_W = $clog2(CHAR_W);
  localparam logic [BC_W-1:0] LAST = BC_W'(CHAR_W - 1);

  logic [NSYNC-1:0] raw, synced;
  logic sck_s, ss_s, mosi_s, sck_d, rise, fall, loaded;
  logic [BC_W-1:0]   cnt;
  logic [CHAR_W-1:0] tx_sh, rx_sh;

  assign raw = {sck_i, ss_n_i, mosi_i};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    logic q1, q2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q1 <= SYNC_RST[g];
        q2 <= SYNC_RST[g];
      end else begin
        q1 <= raw[g];
        q2 <= q1;
      end
    end
    assign synced[g] = q2;
  end

  assign {sck_s, ss_s, mosi_s} = synced;
  assign rise     = sck_s && !sck_d;
  assign fall     = !sck_s && sck_d;
  assign selected = !ss_s;
  assign active   = en && selected;
  assign ready    = en && (cnt == '0) && !loaded;
  assign miso     = tx_sh[CHAR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d   <= 1'b0;
      cnt     <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      loaded  <= 1'b0;
      done    <= 1'b0;
      rx_data <= '0;
    end else begin
      done  <= 1'b0;
      sck_d <= sck_s;
      if (load) begin
        tx_sh  <= tx_data;
        loaded <= 1'b1;
      end
      if (!active) begin
        cnt <= '0;
      end else if (rise) begin
        rx_sh <= {rx_sh[CHAR_W-2:0], mosi_s};
        if (cnt == LAST) begin
          cnt     <= '0;
          done    <= 1'b1;
          rx_data <= {rx_sh[CHAR_W-2:0], mosi_s};
          tx_sh   <= '0;
          loaded  <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (fall && cnt != '0) begin
        tx_sh <= {tx_sh[CHAR_W-2:0], 1'b0};
      end
    end
  end

  assert_done_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rise && active));
  assert_load_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !ready);
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl import spi_ctrl_pkg::*; #(
  parameter int REG_W  = 16,
  parameter int CHAR_W = 8,
  parameter int DIV_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_o,
  output logic              m_sck_o,
  output logic              m_mosi_o,
  input  logic              m_miso_i,
  output logic              m_ss_n_o,
  input  logic              s_sck_i,
  input  logic              s_ss_n_i,
  input  logic              s_mosi_i,
  output logic              s_miso_o
);
  logic ctl_en, ctl_master, load;
  logic [DIV_W-1:0]  ctl_div;
  logic [CHAR_W-1:0] tx_data, m_rx, s_rx, rx_data;
  logic m_busy, m_ready, m_done, s_sel, s_active, s_ready, s_done;
  logic eng_ready, role_lock, act_bit, rx_done;

  assign eng_ready = ctl_en && (ctl_master ? m_ready : s_ready);
  assign role_lock = m_busy || s_active;
  assign act_bit   = ctl_master ? m_busy : s_sel;
  assign rx_done   = m_done || s_done;
  assign rx_data   = m_done ? m_rx : s_rx;
  assign m_ss_n_o  = !m_busy;

  spi_regs #(.REG_W(REG_W), .CHAR_W(CHAR_W), .DIV_W(DIV_W)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_ready(eng_ready), .role_lock(role_lock), .act_bit(act_bit),
    .rx_done(rx_done), .rx_data(rx_data),
    .load(load), .tx_data(tx_data),
    .ctl_en(ctl_en), .ctl_master(ctl_master), .ctl_div(ctl_div),
    .irq(irq_o)
  );

  spi_mst_eng #(.CHAR_W(CHAR_W), .DIV_W(DIV_W)) mst_i (
    .clk(clk), .rst_n(rst_n),
    .start(load && ctl_master), .tx_data(tx_data), .div(ctl_div),
    .miso(m_miso_i), .busy(m_busy), .ready(m_ready),
    .sck(m_sck_o), .mosi(m_mosi_o), .done(m_done), .rx_data(m_rx)
  );

  spi_slv_eng #(.CHAR_W(CHAR_W)) slv_i (
    .clk(clk), .rst_n(rst_n),
    .en(ctl_en && !ctl_master), .load(load && !ctl_master),
    .tx_data(tx_data),
    .sck_i(s_sck_i), .ss_n_i(s_ss_n_i), .mosi_i(s_mosi_i),
    .miso(s_miso_o), .selected(s_sel), .active(s_active),
    .ready(s_ready), .done(s_done), .rx_data(s_rx)
  );

  always_ff @(posedge clk) begin
    if (rst_n && bus_sel && !bus_wr && bus_addr == OFF_STAT) begin
      assert_status_rsvd_zero_R2: assert (bus_rdata[REG_W-1:ST_ACT_BIT+1] == '0)
        else $error("status reserved bits nonzero");
    end
  end

  assert_one_done_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_done && s_done));
endmodule

// File: tb/spi_port_ctrl_tb_top.sv
module spi_port_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq_o, m_sck_o, m_mosi_o, m_miso_i, m_ss_n_o, s_miso_o;
  logic s_sck_i = 1'b0, s_ss_n_i = 1'b1, s_mosi_i = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  spi_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .m_sck_o(m_sck_o), .m_mosi_o(m_mosi_o),
    .m_miso_i(m_miso_i), .m_ss_n_o(m_ss_n_o), .s_sck_i(s_sck_i),
    .s_ss_n_i(s_ss_n_i), .s_mosi_i(s_mosi_i), .s_miso_o(s_miso_o)
  );

  // external slave model for the master path
  logic [7:0] bs_resp = 8'h00;
  logic [7:0] bs_sh = 8'h00;
  logic [7:0] bs_cap = 8'h00;
  logic bs_prev_ss = 1'b1;
  assign m_miso_i = bs_sh[7];
  always @(negedge m_ss_n_o or negedge m_sck_o) begin
    if (bs_prev_ss && !m_ss_n_o) bs_sh = bs_resp;
    else if (!m_ss_n_o) bs_sh = {bs_sh[6:0], 1'b0};
    bs_prev_ss = m_ss_n_o;
  end
  always @(posedge m_sck_o) bs_cap = {bs_cap[6:0], m_mosi_o};

  // cycle counters for select-low and sck-high
  logic cnt_clr = 1'b1;
  int lowcnt = 0, highcnt = 0;
  always @(negedge clk) begin
    if (cnt_clr) begin lowcnt = 0; highcnt = 0; end
    else begin
      if (!m_ss_n_o) lowcnt++;
      if (m_sck_o) highcnt++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic wait_full(output logic [15:0] st);
    for (int k = 0; k < 400; k++) begin
      rd(3'h0, st);
      if (st[1]) break;
    end
  endtask

  task automatic mxfer(input logic [7:0] tx, input logic [7:0] resp,
                       output logic [7:0] got);
    logic [15:0] st, d;
    bs_resp = resp;
    wr(3'h2, {8'h00, tx});
    wait_full(st);
    rd(3'h4, d);
    got = d[7:0];
  endtask

  task automatic sxfer(input logic [7:0] b, output logic [7:0] got);
    got = 8'h00;
    for (int i = 7; i >= 0; i--) begin
      s_mosi_i = b[i];
      repeat (4) @(negedge clk);
      got = {got[6:0], s_miso_o};
      s_sck_i = 1'b1;
      repeat (4) @(negedge clk);
      s_sck_i = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic sframe(input logic [7:0] b, output logic [7:0] got);
    s_ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    sxfer(b, got);
    s_ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic run_tests();
    logic [15:0] d, st;
    logic [7:0] got, exp_b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    rd(3'h0, d); chk("R6 R5 R3 status after reset", d, 16'h0001);
    rd(3'h6, d); chk("R8 control after reset", d, 16'h0000);
    chk("R7 irq after reset", irq_o, 0);
    chk("R9 select idle high after reset", m_ss_n_o, 1);

    // R1 register decode and read-back
    wr(3'h6, 16'h001C);
    rd(3'h6, d); chk("R1 control read-back", d, 16'h001C);
    // R12 disabled master keeps byte pending
    wr(3'h6, 16'h0012);
    wr(3'h2, 16'h003C);
    rd(3'h2, d); chk("R1 transmit read-back", d, 16'h003C);
    repeat (20) @(negedge clk);
    rd(3'h0, d); chk("R12 pending while disabled", d, 16'h0000);
    chk("R12 no select while disabled", m_ss_n_o, 1);
    bs_resp = 8'hC3;
    wr(3'h6, 16'h0013);
    wait_full(st);
    chk("R7 irq with enable and full", irq_o, 1);
    rd(3'h4, d); chk("R9 master receive byte", d, 16'h00C3);
    chk("R9 master sent byte", bs_cap, 8'h3C);
    chk("R7 irq drops after read", irq_o, 0);
    rd(3'h0, d); chk("R5 full cleared by read", d, 16'h0001);

    // R9 divider sweep
    for (int dv = 0; dv < 4; dv++) begin
      wr(3'h6, 16'(3 | (dv << 2)));
      @(negedge clk); cnt_clr = 1'b0;
      bs_resp = 8'h5A;
      wr(3'h2, 16'h00A5);
      wait_full(st);
      chk("R7 no irq with enable clear", irq_o, 0);
      rd(3'h4, d);
      chk("R9 divider receive", d, 16'h005A);
      chk("R9 select-low cycles", lowcnt, 16 << dv);
      chk("R9 sck-high cycles", highcnt, 8 << dv);
      cnt_clr = 1'b1;
    end

    // R3 busy bit and R8 role lock in master mode
    wr(3'h6, 16'h000F);
    bs_resp = 8'h77;
    wr(3'h2, 16'h0011);
    repeat (6) @(negedge clk);
    rd(3'h0, d); chk("R3 busy during transfer", d, 16'h0005);
    wr(3'h6, 16'h000D);
    rd(3'h6, d); chk("R8 role kept during master transfer", d, 16'h000F);
    wait_full(st);
    chk("R3 busy clear when full", st, 16'h0003);
    rd(3'h4, d); chk("R3 receive after busy", d, 16'h0077);

    // R11 overrun in master mode
    wr(3'h6, 16'h0003);
    mxfer(8'h12, 8'h34, got);
    bs_resp = 8'h56;
    wr(3'h2, 16'h0012);
    wait_full(st);
    bs_resp = 8'h9E;
    wr(3'h2, 16'h0078);
    repeat (40) @(negedge clk);
    rd(3'h0, d); chk("R11 full stays set", d, 16'h0003);
    rd(3'h4, d); chk("R11 newest byte kept", d, 16'h009E);

    // full master sweep
    for (int v = 0; v < 256; v++) begin
      exp_b = 8'((v * 7 + 3) & 255);
      mxfer(8'(v), exp_b, got);
      chk("R9 sweep receive", got, exp_b);
      chk("R9 sweep transmit", bs_cap, v);
    end

    // slave mode: select mirror and role lock
    wr(3'h6, 16'h0001);
    rd(3'h0, d); chk("R4 slave deselected", d, 16'h0001);
    s_ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'h0, d); chk("R4 slave selected", d, 16'h0005);
    wr(3'h6, 16'h0003);
    rd(3'h6, d); chk("R8 role kept while selected", d, 16'h0001);
    s_ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'h0, d); chk("R4 slave released", d, 16'h0001);

    // slave sweep
    for (int v = 0; v < 256; v++) begin
      exp_b = 8'((v * 13 + 5) & 255);
      wr(3'h2, {8'h00, exp_b});
      repeat (2) @(negedge clk);
      rd(3'h0, d); chk("R6 slave took byte", d, 16'h0001);
      sframe(8'(v), got);
      rd(3'h0, d); chk("R5 slave full", d, 16'h0003);
      rd(3'h4, d); chk("R10 slave receive", d, v);
      chk("R10 slave transmit", got, exp_b);
    end

    // R10 unloaded frame sends zeros
    sframe(8'h81, got);
    chk("R10 unloaded frame zero", got, 8'h00);
    rd(3'h4, d); chk("R10 unloaded frame receive", d, 16'h0081);

    // R11 slave overrun and R7 irq in slave mode
    wr(3'h6, 16'h0011);
    sframe(8'h11, got);
    chk("R7 slave irq", irq_o, 1);
    sframe(8'h22, got);
    rd(3'h0, d); chk("R11 slave full stays", d, 16'h0003);
    rd(3'h4, d); chk("R11 slave newest byte", d, 16'h0022);
    chk("R7 slave irq cleared", irq_o, 0);
  endtask

  initial begin
    bit timed_out = 1'b0;
    fork
      run_tests();
      begin
        repeat (190000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule